// File: doc/BRIEF.md
# Periodic interrupt and update timing unit for a calendar clock

This unit holds the timing registers of a calendar clock. A 15-bit prescaler advances on each 32.768 kHz time-base strobe. The prescaler produces three events:
- a periodic flag, at a power-of-two rate picked by a 4-bit rate code;
- a one-second update strobe, which sets an update-ended flag;
- an update-in-progress indication, raised for a short window just before each update.

Three flags (periodic, alarm, update-ended) share one active-high interrupt line. Each flag can be masked by its own enable bit.

Software reaches the unit through an index/data pair:
- a write to the index port selects a register;
- data writes go to the selected register;
- `rdata` always shows the selected register;
- a data read of the flag register clears all of its flags.

The rest of the calendar uses the update strobe to advance the time fields. That logic, the alarm comparison and the battery domain sit outside this unit. They connect through `upd_strobe`, `alarm_match` and `pwr_ok`.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset, the rate register (index 0x0A), the control register (0x0B) and the flag register (0x0C) all read 0x00.
- R2: The registers sit at indices 0x0A to 0x0D, and any other index reads 0x00. The rate register holds the update-in-progress flag in bit 7, the divider code in bits 6-4 and the rate code in bits 3-0. A write to bit 7 is ignored. The control register is fully writable. Writes to the flag register (0x0C) and the power register (0x0D) have no effect.
- R3: The prescaler advances only while the divider code is 010. Codes 110 and 111 hold it at zero. Every other code freezes it. While it is not advancing, no periodic, update or update-in-progress events occur.
- R4: Rate codes 1 and 2 give periodic flags every 128 and 256 time-base ticks. Rate codes 3 to 15 give flags every 2^(code-1) ticks. All periods are aligned to the prescaler.
- R5: Rate code 0 never sets the periodic flag.
- R6: Update-in-progress (rate register bit 7) is high for exactly the last UIP_LEAD ticks (default 8) before each update. It is low at all other times.
- R7: Each 32768th tick produces a one-cycle `upd_strobe`. The same edge sets the update-ended flag.
- R8: While control bit 7 (halt) is set, there is no update strobe, no update-ended flag and no update-in-progress.
- R9: The flag register reads {IRQF, PF, AF, UF, 0000}. IRQF is the OR of PF with control bit 6, AF with control bit 5, and UF with control bit 4. `irq` equals IRQF.
- R10: A data read of the flag register clears PF, AF and UF on that edge. A flag set by an event on the same edge is kept.
- R11: A one-cycle `alarm_match` sets AF.
- R12: The power register reads `pwr_ok` in bit 7 and zero in bits 6-0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe per 32.768 kHz time-base tick |
| pwr_ok | input | 1 | Supply-good indication shown in the power register |
| alarm_match | input | 1 | Pulse from the alarm comparator; sets AF |
| idx_we | input | 1 | Load the index register from `wdata` |
| dat_we | input | 1 | Write `wdata` to the selected register |
| dat_re | input | 1 | Data read strobe; clears the flags when the flag register is selected |
| wdata | input | 8 | Write data for index and data writes |
| rdata | output | 8 | Contents of the selected register |
| irq | output | 1 | Active-high interrupt request, equal to IRQF |
| upd_strobe | output | 1 | One-cycle pulse at each one-second update |

## Verification
Most faults in this unit end up in the prescaler. A prescaler that is off by even one tick moves the update-in-progress window and the update strobe away from the expected cycles. That shows in rate register bit 7 or on `upd_strobe` in the same cycle. A wrong rate decode changes the spacing between `irq` rises within a few periods, so short rate codes expose it in tens of cycles. A flag that fails to clear, or that is lost on a read in the same cycle as an event, shows on `irq` one cycle after the read edge.

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq #(
  parameter int         PRESC_W  = 15,
  parameter int         UIP_LEAD = 8,
  parameter logic [7:0] BASE_IDX = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       pwr_ok,
  input  logic       alarm_match,
  input  logic       idx_we,
  input  logic       dat_we,
  input  logic       dat_re,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       upd_strobe
);

  localparam logic [7:0]         IDX_A    = BASE_IDX;
  localparam logic [7:0]         IDX_B    = BASE_IDX + 8'd1;
  localparam logic [7:0]         IDX_C    = BASE_IDX + 8'd2;
  localparam logic [7:0]         IDX_D    = BASE_IDX + 8'd3;
  localparam logic [2:0]         DIV_RUN  = 3'b010;
  localparam logic [PRESC_W-1:0] UIP_FROM = PRESC_W'((1 << PRESC_W) - UIP_LEAD);

  logic [7:0]         idx_q;
  logic [2:0]         div_q;
  logic [3:0]         rate_q;
  logic [7:0]         ctl_q;
  logic [PRESC_W-1:0] cnt_q;
  logic               pf_q, af_q, uf_q, upd_q;

  logic               run, div_rst, pf_ev, sec_ev, rd_c, uip, irqf;
  logic [3:0]         kexp;
  logic [PRESC_W-1:0] pmask;

  assign run     = (div_q == DIV_RUN) && tick_en;
  assign div_rst = (div_q[2:1] == 2'b11);
  assign kexp    = (rate_q < 4'd3) ? rate_q + 4'd6 : rate_q - 4'd1;
  assign pmask   = (PRESC_W'(1) << kexp) - PRESC_W'(1);
  assign pf_ev   = run && (rate_q != 4'd0) && ((cnt_q & pmask) == pmask);
  assign sec_ev  = run && !ctl_q[7] && (&cnt_q);
  assign uip     = (div_q == DIV_RUN) && !ctl_q[7] && (cnt_q >= UIP_FROM);
  assign rd_c    = dat_re && (idx_q == IDX_C);
  assign irqf    = (pf_q && ctl_q[6]) || (af_q && ctl_q[5]) || (uf_q && ctl_q[4]);

  assign irq        = irqf;
  assign upd_strobe = upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      div_q  <= '0;
      rate_q <= '0;
      ctl_q  <= '0;
      cnt_q  <= '0;
      pf_q   <= 1'b0;
      af_q   <= 1'b0;
      uf_q   <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      if (idx_we) idx_q <= wdata;
      if (dat_we && idx_q == IDX_A) begin
        div_q  <= wdata[6:4];
        rate_q <= wdata[3:0];
      end
      if (dat_we && idx_q == IDX_B) ctl_q <= wdata;
      if (div_rst)  cnt_q <= '0;
      else if (run) cnt_q <= cnt_q + PRESC_W'(1);
      upd_q <= sec_ev;
      pf_q  <= pf_ev       || (pf_q && !rd_c);
      af_q  <= alarm_match || (af_q && !rd_c);
      uf_q  <= sec_ev      || (uf_q && !rd_c);
    end
  end

  always_comb begin
    case (idx_q)
      IDX_A:   rdata = {uip, div_q, rate_q};
      IDX_B:   rdata = ctl_q;
      IDX_C:   rdata = {irqf, pf_q, af_q, uf_q, 4'b0000};
      IDX_D:   rdata = {pwr_ok, 7'b0};
      default: rdata = 8'h00;
    endcase
  end

  AST_UPD_AFTER_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> $past(uip)); // R6
  AST_NO_UPD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> !$past(ctl_q[7])); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !pf_ev && !sec_ev && !alarm_match) |=> !irq); // R10
  AST_RATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 4'd0 && !pf_q) |=> !pf_q); // R5
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |=> (cnt_q == '0)); // R3
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q); // R7

endmodule

// File: tb/test_rtc_periodic_irq.sv
module test_rtc_periodic_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1, pwr_ok = 1'b1, alarm_match = 1'b0;
  logic idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq, upd_strobe;

  rtc_periodic_irq i_rtc_periodic_irq (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwr_ok(pwr_ok),
    .alarm_match(alarm_match), .idx_we(idx_we), .dat_we(dat_we),
    .dat_re(dat_re), .wdata(wdata), .rdata(rdata), .irq(irq),
    .upd_strobe(upd_strobe));

  always #5 clk = ~clk;

  int errs = 0, checks = 0, cyc_n = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_idx, m_b;
  int  m_div, m_rate, m_cnt, k;
  bit  m_pf, m_af, m_uf, m_upd, m_run, m_pfe, m_sece, m_clr;

  always @(posedge clk) begin
    cyc_n++;
    if (!rst_n) begin
      m_idx = 0; m_b = 0; m_div = 0; m_rate = 0; m_cnt = 0;
      m_pf = 0; m_af = 0; m_uf = 0; m_upd = 0;
    end else begin
      m_run  = (m_div == 2) && tick_en;
      k      = (m_rate < 3) ? m_rate + 6 : m_rate - 1;
      m_pfe  = m_run && m_rate != 0 && ((m_cnt % (1 << k)) == (1 << k) - 1);
      m_sece = m_run && !m_b[7] && m_cnt == 32767;
      m_clr  = dat_re && m_idx == 8'h0C;
      if (m_div >= 6) m_cnt = 0;
      else if (m_run) m_cnt = (m_cnt + 1) % 32768;
      m_pf  = m_pfe || (m_pf && !m_clr);
      m_uf  = m_sece || (m_uf && !m_clr);
      m_af  = alarm_match || (m_af && !m_clr);
      m_upd = m_sece;
      if (dat_we && m_idx == 8'h0A) begin m_div = wdata[6:4]; m_rate = wdata[3:0]; end
      if (dat_we && m_idx == 8'h0B) m_b = wdata;
      if (idx_we) m_idx = wdata;
    end
  end

  function automatic bit m_irq();
    return (m_pf && m_b[6]) || (m_af && m_b[5]) || (m_uf && m_b[4]);
  endfunction

  function automatic logic [7:0] m_rd();
    bit u;
    u = (m_div == 2) && !m_b[7] && m_cnt >= 32768 - 8;
    case (m_idx)
      8'h0A: return {u, 3'(m_div), 4'(m_rate)};
      8'h0B: return m_b;
      8'h0C: return {m_irq(), m_pf, m_af, m_uf, 4'b0};
      8'h0D: return {pwr_ok, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rdata == m_rd(), "R2 rdata vs model", rdata, m_rd());
      chk(irq == m_irq(), "R9 irq vs model", irq, m_irq());
      chk(upd_strobe == m_upd, "R7 upd_strobe vs model", upd_strobe, m_upd);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic set_idx(input logic [7:0] i);
    tick(); idx_we = 1; wdata = i;
    tick(); idx_we = 0;
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] v);
    set_idx(i);
    dat_we = 1; wdata = v;
    tick(); dat_we = 0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] v);
    set_idx(i);
    v = rdata; dat_re = 1;
    tick(); dat_re = 0;
  endtask

  task automatic wait_irq();
    while (!irq) tick();
  endtask

  task automatic rate_check(input int code, input int period);
    logic [7:0] v;
    int t1, t2;
    wr(8'h0A, 8'h20 | 8'(code));
    wait_irq(); rd(8'h0C, v);
    wait_irq(); t1 = cyc_n; rd(8'h0C, v);
    wait_irq(); t2 = cyc_n; rd(8'h0C, v);
    chk(t2 - t1 == period, $sformatf("R4 period for rate %0d", code), t2 - t1, period);
  endtask

  initial begin
    int t0;
    #200000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, u;
    repeat (3) tick();
    rst_n = 1;
    rd(8'h0A, v); chk(v == 8'h00, "R1 rate reg reset", v, 8'h00);
    rd(8'h0B, v); chk(v == 8'h00, "R1 control reg reset", v, 8'h00);
    rd(8'h0C, v); chk(v == 8'h00, "R1 flag reg reset", v, 8'h00);
    rd(8'h0D, v); chk(v == 8'h80, "R12 power bit set", v, 8'h80);
    pwr_ok = 0;
    rd(8'h0D, v); chk(v == 8'h00, "R12 power bit clear", v, 8'h00);
    pwr_ok = 1;
    rd(8'h05, v); chk(v == 8'h00, "R2 unmapped index", v, 8'h00);
    wr(8'h0A, 8'h83);
    rd(8'h0A, v); chk(v == 8'h03, "R2 bit7 write ignored", v, 8'h03);
    wr(8'h0C, 8'hFF); rd(8'h0C, v); chk(v == 8'h00, "R2 flag reg not writable", v, 8'h00);
    wr(8'h0D, 8'h7F); rd(8'h0D, v); chk(v == 8'h80, "R2 power reg not writable", v, 8'h80);

    wr(8'h0B, 8'h40);
    repeat (200) tick();
    chk(irq == 0, "R3 frozen divider no periodic", irq, 0);
    wr(8'h0A, 8'h67);
    repeat (300) tick();
    chk(irq == 0, "R3 divider held in reset", irq, 0);
    wr(8'h0A, 8'h47);
    repeat (300) tick();
    chk(irq == 0, "R3 test-mode divider frozen", irq, 0);

    rate_check(3, 4);
    rate_check(4, 8);
    rate_check(7, 64);
    rate_check(1, 128);
    rate_check(2, 256);

    wr(8'h0A, 8'h20);
    rd(8'h0C, v);
    repeat (600) tick();
    rd(8'h0C, v); chk((v & 8'h40) == 0, "R5 rate 0 no PF", v & 8'h40, 0);

    wr(8'h0B, 8'h10);
    while (!upd_strobe) tick();
    chk(irq == 1, "R7 UF raises irq with strobe", irq, 1);
    tick(); chk(upd_strobe == 0, "R7 strobe one cycle", upd_strobe, 0);
    rd(8'h0C, v);
    chk((v & 8'hF0) == 8'h90, "R9 flag reg IRQF+UF", v & 8'hF0, 8'h90);
    chk(irq == 0, "R10 read clears", irq, 0);
    set_idx(8'h0A);
    n = 0;
    while (!upd_strobe) begin if (rdata[7]) n++; tick(); end
    chk(n == 8, "R6 UIP window length", n, 8);

    wr(8'h0B, 8'h20);
    rd(8'h0C, v);
    alarm_match = 1; tick(); alarm_match = 0;
    chk(irq == 1, "R11 alarm sets AF", irq, 1);
    rd(8'h0C, v); chk((v & 8'hE0) == 8'hA0, "R11 AF in flag reg", v & 8'hE0, 8'hA0);
    set_idx(8'h0C);
    dat_re = 1; alarm_match = 1; tick(); dat_re = 0; alarm_match = 0;
    chk(irq == 1, "R10 same-edge event kept", irq, 1);
    rd(8'h0C, v); tick();
    chk(irq == 0, "R10 cleared after read", irq, 0);

    wr(8'h0B, 8'h90);
    rd(8'h0C, v);
    set_idx(8'h0A);
    n = 0; u = 0;
    repeat (33000) begin
      if (upd_strobe) n++;
      if (rdata[7]) u++;
      tick();
    end
    chk(n == 0, "R8 no strobe while halted", n, 0);
    chk(u == 0, "R8 no UIP while halted", u, 0);
    chk(irq == 0, "R8 no UF while halted", irq, 0);
    wr(8'h0B, 8'h00);
    repeat (4) tick();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule